// File: doc/BRIEF.md
# Monotonic Reuse-Buffer Fill Address Generator

This block produces the read addresses that load an on-chip reuse buffer from external DRAM. The buffered data is what a nest of loops touches through an affine access function. Address = BASE + CI*i + CJ*j + CK*k. The two inner iterators i (0..I_N-1) and j (0..J_N-1) form the generator's state. The outer iterator k arrives on an input port and stays fixed during one fill. The generator does not count through the loop nest. It emits every distinct address the loops touch once, in strictly ascending order. Addresses reached by several iterator pairs appear only once, and values the function never reaches are skipped. A DRAM controller that sees this stream therefore opens each row at most once per fill.

Each step evaluates every lattice point of the inner iteration box combinationally against the current address. It keeps the points that lie strictly ahead and picks the smallest of them. The result is a piecewise-linear choice: each branch is the sign of an affine difference. The chosen point becomes the next state. When no point lies ahead, the fill is complete and `done` rises. Addresses leave through a valid/ready handshake.

Top module: `ag_reuse_fill_gen`

## Requirements
- R1: While reset is asserted and after it is released, `addr_valid` and `done` are 0.
- R2: One cycle after `start` is sampled high, `addr_valid` is 1 and `addr` equals the address of iterator vector (0,0) for the sampled `outer_k`. With defaults, that address is 16*k.
- R3: With defaults (BASE=0, CI=2, CJ=4, CK=16, i in 0..2, j in 0..1), a fill for k=0 emits exactly 0, 2, 4, 6, 8 in that order. A fill for k emits the same five values plus 16*k. Each value is strictly larger than the one before it.
- R4: An address the access function cannot reach is never emitted. With defaults and k=0, the odd values 1, 3, 5 and 7 never appear.
- R5: While `addr_valid` is 1 and `addr_ready` is 0, `addr` and `addr_valid` hold their values.
- R6: One cycle after the handshake on the last address, `done` is 1 and `addr_valid` is 0. Both hold until the next restart.
- R7: A `start` pulse in the middle of a fill restarts it. In the next cycle the first address of the fill is presented again.
- R8: If `outer_k` differs from the value latched for the current fill while the block is filling or done, the fill restarts with the new value and no `start` is needed. In the next cycle `addr` is the first address for the new k.
- R9: While `addr_ready` stays 1, a new address is presented in every cycle until the fill ends.
- R10: Before the first `start`, holding `addr_ready` high produces no valid address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin a new fill from iterator vector (0,0) |
| outer_k | input | KW | Outer loop iterator for this fill |
| addr_ready | input | 1 | Consumer accepts the presented address |
| addr_valid | output | 1 | An address is presented |
| addr | output | AW | Fill address |
| done | output | 1 | All distinct addresses of the fill have been accepted |

## Verification
The ordering, holding and done-persistence properties assume that `outer_k` keeps its latched value and `start` stays low across the cycle under test. Each of these properties excludes cycles in which a restart is requested. The bench changes `outer_k` and pulses `start` only in the scenarios that test restarts. Its other scenarios hold those inputs steady and drive them at the falling edge. A reachability property confirms that every presented address matches some iterator pair inside the box for the latched k.

// File: rtl/ag_pkg.sv
package ag_pkg;

  typedef enum logic [1:0] {
    FILL_IDLE = 2'd0,
    FILL_RUN  = 2'd1,
    FILL_DONE = 2'd2
  } fill_state_e;

  // Affine access function evaluated at 32 bits; callers truncate.
  function automatic logic [31:0] lattice_addr(
    input logic [31:0] base,
    input logic [31:0] ci,
    input logic [31:0] cj,
    input logic [31:0] ck,
    input logic [31:0] i,
    input logic [31:0] j,
    input logic [31:0] k
  );
    return base + ci * i + cj * j + ck * k;
  endfunction

endpackage

// File: rtl/ag_lattice_point.sv
// One fixed point (PI, PJ) of the inner iteration box: its address for the
// latched outer iterator, and whether it lies strictly ahead of the cursor.
module ag_lattice_point
  import ag_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned KW   = 4,
  parameter int unsigned BASE = 0,
  parameter int unsigned CI   = 2,
  parameter int unsigned CJ   = 4,
  parameter int unsigned CK   = 16,
  parameter int unsigned PI   = 0,
  parameter int unsigned PJ   = 0
) (
  input  logic [KW-1:0] fill_k,
  input  logic [AW-1:0] cur_addr,
  output logic [AW-1:0] pt_addr,
  output logic          pt_ahead
);

  always_comb begin
    pt_addr  = AW'(lattice_addr(32'(BASE), 32'(CI), 32'(CJ), 32'(CK),
                                32'(PI), 32'(PJ), 32'(fill_k)));
    // sign of (pt_addr - cur_addr - 1)
    pt_ahead = (pt_addr > cur_addr);
  end

endmodule

// File: rtl/ag_min_pick.sv
// Chain reduction: the smallest candidate address among those flagged ahead.
// Ties keep the lower candidate index.
module ag_min_pick #(
  parameter int unsigned N  = 6,
  parameter int unsigned AW = 16,
  parameter int unsigned IW = 2,
  parameter int unsigned JW = 1
) (
  input  logic [N-1:0]         cand_ok,
  input  logic [N-1:0][AW-1:0] cand_addr,
  input  logic [N-1:0][IW-1:0] cand_i,
  input  logic [N-1:0][JW-1:0] cand_j,
  output logic                 pick_found,
  output logic [IW-1:0]        pick_i,
  output logic [JW-1:0]        pick_j
);

  logic [N-1:0]         best_ok;
  logic [N-1:0][AW-1:0] best_addr;
  logic [N-1:0][IW-1:0] best_i;
  logic [N-1:0][JW-1:0] best_j;

  genvar n;
  generate
    for (n = 0; n < N; n++) begin : g_stage
      if (n == 0) begin : g_first
        always_comb begin
          best_ok[n]   = cand_ok[n];
          best_addr[n] = cand_addr[n];
          best_i[n]    = cand_i[n];
          best_j[n]    = cand_j[n];
        end
      end else begin : g_rest
        logic take;
        always_comb begin
          take = cand_ok[n] && (!best_ok[n-1] || (cand_addr[n] < best_addr[n-1]));
          best_ok[n]   = best_ok[n-1] | cand_ok[n];
          best_addr[n] = take ? cand_addr[n] : best_addr[n-1];
          best_i[n]    = take ? cand_i[n]    : best_i[n-1];
          best_j[n]    = take ? cand_j[n]    : best_j[n-1];
        end
      end
    end
  endgenerate

  assign pick_found = best_ok[N-1];
  assign pick_i     = best_i[N-1];
  assign pick_j     = best_j[N-1];

endmodule

// File: rtl/ag_fill_ctrl.sv
// Fill sequencing: iterator state, latched outer iterator, handshake, done.
module ag_fill_ctrl
  import ag_pkg::*;
#(
  parameter int unsigned KW = 4,
  parameter int unsigned IW = 2,
  parameter int unsigned JW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [KW-1:0] outer_k,
  input  logic          addr_ready,
  input  logic          nxt_found,
  input  logic [IW-1:0] nxt_i,
  input  logic [JW-1:0] nxt_j,
  output logic [IW-1:0] cur_i,
  output logic [JW-1:0] cur_j,
  output logic [KW-1:0] fill_k,
  output logic          addr_valid,
  output logic          done
);

  fill_state_e state_q, state_d;
  logic [IW-1:0] i_d;
  logic [JW-1:0] j_d;
  logic          iter_en;
  logic          k_en;
  logic          restart;
  logic          accept;

  always_comb begin
    restart = start || ((state_q != FILL_IDLE) && (outer_k != fill_k));
    accept  = (state_q == FILL_RUN) && addr_ready;

    state_d = state_q;
    if (restart) begin
      state_d = FILL_RUN;
    end else if (accept) begin
      state_d = nxt_found ? FILL_RUN : FILL_DONE;
    end

    iter_en = restart || (accept && nxt_found);
    i_d     = restart ? '0 : nxt_i;
    j_d     = restart ? '0 : nxt_j;
    k_en    = restart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FILL_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_i <= '0;
      cur_j <= '0;
    end else if (iter_en) begin
      cur_i <= i_d;
      cur_j <= j_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_k <= '0;
    end else if (k_en) begin
      fill_k <= outer_k;
    end
  end

  assign addr_valid = (state_q == FILL_RUN);
  assign done       = (state_q == FILL_DONE);

endmodule

// File: rtl/ag_reuse_fill_gen.sv
module ag_reuse_fill_gen
  import ag_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned KW   = 4,
  parameter int unsigned I_N  = 3,
  parameter int unsigned J_N  = 2,
  parameter int unsigned BASE = 0,
  parameter int unsigned CI   = 2,
  parameter int unsigned CJ   = 4,
  parameter int unsigned CK   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [KW-1:0] outer_k,
  input  logic          addr_ready,
  output logic          addr_valid,
  output logic [AW-1:0] addr,
  output logic          done
);

  localparam int unsigned IW = (I_N > 1) ? $clog2(I_N) : 1;
  localparam int unsigned JW = (J_N > 1) ? $clog2(J_N) : 1;
  localparam int unsigned NP = I_N * J_N;

  logic [IW-1:0] cur_i;
  logic [JW-1:0] cur_j;
  logic [KW-1:0] fill_k;
  logic [AW-1:0] cur_addr;

  logic [NP-1:0]         pt_ok;
  logic [NP-1:0][AW-1:0] pt_addr;
  logic [NP-1:0][IW-1:0] pt_i;
  logic [NP-1:0][JW-1:0] pt_j;

  logic          nxt_found;
  logic [IW-1:0] nxt_i;
  logic [JW-1:0] nxt_j;

  assign cur_addr = AW'(lattice_addr(32'(BASE), 32'(CI), 32'(CJ), 32'(CK),
                                     32'(cur_i), 32'(cur_j), 32'(fill_k)));

  genvar gi, gj;
  generate
    for (gj = 0; gj < J_N; gj++) begin : g_j
      for (gi = 0; gi < I_N; gi++) begin : g_i
        localparam int unsigned IDX = gj * I_N + gi;
        ag_lattice_point #(
          .AW(AW), .KW(KW), .BASE(BASE), .CI(CI), .CJ(CJ), .CK(CK),
          .PI(gi), .PJ(gj)
        ) u_pt (
          .fill_k   (fill_k),
          .cur_addr (cur_addr),
          .pt_addr  (pt_addr[IDX]),
          .pt_ahead (pt_ok[IDX])
        );
        assign pt_i[IDX] = IW'(gi);
        assign pt_j[IDX] = JW'(gj);
      end
    end
  endgenerate

  ag_min_pick #(.N(NP), .AW(AW), .IW(IW), .JW(JW)) u_pick (
    .cand_ok    (pt_ok),
    .cand_addr  (pt_addr),
    .cand_i     (pt_i),
    .cand_j     (pt_j),
    .pick_found (nxt_found),
    .pick_i     (nxt_i),
    .pick_j     (nxt_j)
  );

  ag_fill_ctrl #(.KW(KW), .IW(IW), .JW(JW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .outer_k    (outer_k),
    .addr_ready (addr_ready),
    .nxt_found  (nxt_found),
    .nxt_i      (nxt_i),
    .nxt_j      (nxt_j),
    .cur_i      (cur_i),
    .cur_j      (cur_j),
    .fill_k     (fill_k),
    .addr_valid (addr_valid),
    .done       (done)
  );

  assign addr = cur_addr;

endmodule

// File: rtl/ag_reuse_fill_chk.sv
module ag_reuse_fill_chk #(
  parameter int unsigned AW   = 16,
  parameter int unsigned KW   = 4,
  parameter int unsigned I_N  = 3,
  parameter int unsigned J_N  = 2,
  parameter int unsigned BASE = 0,
  parameter int unsigned CI   = 2,
  parameter int unsigned CJ   = 4,
  parameter int unsigned CK   = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [KW-1:0] outer_k,
  input logic          addr_ready,
  input logic          addr_valid,
  input logic [AW-1:0] addr,
  input logic          done,
  input logic [KW-1:0] fill_k
);

  function automatic logic reachable(input logic [AW-1:0] a, input logic [KW-1:0] k);
    logic hit;
    hit = 1'b0;
    for (int jj = 0; jj < int'(J_N); jj++) begin
      for (int ii = 0; ii < int'(I_N); ii++) begin
        if (a == AW'(BASE + CI * ii + CJ * jj + CK * int'(k))) hit = 1'b1;
      end
    end
    return hit;
  endfunction

  logic steady;
  assign steady = !start && (outer_k == fill_k);

  p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (addr_valid && addr == AW'(BASE + CK * int'($past(outer_k)))));

  p_strict_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_ready && steady) |=> (!addr_valid || addr > $past(addr)));

  p_reachable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> reachable(addr, fill_k));

  p_hold_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready && steady) |=> (addr_valid && $stable(addr)));

  p_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && addr_valid));

  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && steady) |=> done);

endmodule

bind ag_reuse_fill_gen ag_reuse_fill_chk #(
  .AW(AW), .KW(KW), .I_N(I_N), .J_N(J_N),
  .BASE(BASE), .CI(CI), .CJ(CJ), .CK(CK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .outer_k    (outer_k),
  .addr_ready (addr_ready),
  .addr_valid (addr_valid),
  .addr       (addr),
  .done       (done),
  .fill_k     (fill_k)
);

// File: tb/ag_reuse_fill_gen_test.sv
module ag_reuse_fill_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int KW = 4;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [KW-1:0] outer_k;
  logic          addr_ready;
  logic          addr_valid;
  logic [AW-1:0] addr;
  logic          done;

  int n_checks;
  int n_fail;

  ag_reuse_fill_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .outer_k(outer_k),
    .addr_ready(addr_ready), .addr_valid(addr_valid), .addr(addr), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // All driving and sampling happens at the falling edge.
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_start(input logic [KW-1:0] k);
    outer_k = k;
    start   = 1'b1;
    tick();
    start   = 1'b0;
  endtask

  task automatic t_reset_idle();
    check("R1 valid in reset", 32'(addr_valid), 0);
    check("R1 done in reset", 32'(done), 0);
    rst_n = 1'b1;
    addr_ready = 1'b1;
    for (int c = 0; c < 3; c++) begin
      tick();
      check("R10 valid before start", 32'(addr_valid), 0);
      check("R1 done before start", 32'(done), 0);
    end
  endtask

  // Collect a whole fill with ready held high; one address per cycle.
  task automatic t_full_fill(input logic [KW-1:0] k);
    int exp_a;
    addr_ready = 1'b1;
    pulse_start(k);
    check("R2 first valid", 32'(addr_valid), 1);
    check("R2 first addr", 32'(addr), 32'(16 * int'(k)));
    for (int n = 0; n < 5; n++) begin
      exp_a = 16 * int'(k) + 2 * n;
      check("R9 valid every cycle", 32'(addr_valid), 1);
      check("R3 ordered addr", 32'(addr), 32'(exp_a));
      if (k == 0) check("R4 no odd addr", 32'(addr[0]), 0);
      tick();
    end
    check("R6 done after last", 32'(done), 1);
    check("R6 valid low after last", 32'(addr_valid), 0);
    for (int c = 0; c < 3; c++) tick();
    check("R6 done persists", 32'(done), 1);
    check("R6 valid stays low", 32'(addr_valid), 0);
  endtask

  task automatic t_stall();
    addr_ready = 1'b0;
    pulse_start(4'd0);
    for (int c = 0; c < 3; c++) begin
      check("R5 valid held", 32'(addr_valid), 1);
      check("R5 addr held", 32'(addr), 0);
      tick();
    end
    addr_ready = 1'b1;
    tick();
    addr_ready = 1'b0;
    check("R5 advance after accept", 32'(addr), 2);
    tick();
    check("R5 held again", 32'(addr), 2);
  endtask

  task automatic t_restart_start();
    addr_ready = 1'b1;
    pulse_start(4'd0);
    tick();
    tick();
    check("R7 mid fill addr", 32'(addr), 4);
    pulse_start(4'd0);
    check("R7 restarted addr", 32'(addr), 0);
    check("R7 restarted valid", 32'(addr_valid), 1);
    tick();
    check("R7 resumes order", 32'(addr), 2);
  endtask

  task automatic t_outer_change();
    addr_ready = 1'b1;
    pulse_start(4'd0);
    tick();
    tick();
    check("R8 mid fill addr", 32'(addr), 4);
    outer_k = 4'd2;
    tick();
    check("R8 new first addr", 32'(addr), 32);
    for (int n = 1; n < 5; n++) begin
      tick();
      check("R8 new fill order", 32'(addr), 32'(32 + 2 * n));
    end
    tick();
    check("R8 new fill done", 32'(done), 1);
    outer_k = 4'd1;
    tick();
    check("R8 restart from done", 32'(addr), 16);
    check("R8 valid from done", 32'(addr_valid), 1);
  endtask

  initial begin
    n_checks   = 0;
    n_fail     = 0;
    rst_n      = 1'b0;
    start      = 1'b0;
    outer_k    = '0;
    addr_ready = 1'b0;
    tick();
    tick();
    t_reset_idle();
    t_full_fill(4'd0);
    t_full_fill(4'd3);
    t_full_fill(4'd15);
    t_stall();
    t_restart_start();
    t_outer_change();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule